// File: doc/BRIEF.md
# Translation Miss Sequencer

The block steers one address-translation request at a time through a three-level lookup chain. It first asks the level-1 TLB that matches the access kind, which is either the instruction TLB or the data TLB. On a miss it asks a unified level-2 TLB. On a second miss it starts a hardware table walk. Each lookup presents the same key: the virtual address, the address-space identifier, the virtual-machine identifier and the security state of the request. The TLB arrays and the walker sit outside the block. Each one is reached through a level request that is held until a one-cycle response pulse arrives.

Before a walk is issued, the block works out four things from the request and the live configuration. It picks which of two translation bases covers the address. It checks whether walks through that base are switched off. It chooses the descriptor format. It decides whether walk reads use the data cache or go straight to external memory. A switched-off base or a walker error ends the request with a fault. A successful walk refills both the level-2 TLB and the level-1 TLB that missed, and then returns the result.

The state machine has six states:
- IDLE: waits for a request.
- L1: the level-1 lookup. A hit goes to DONE; a miss goes to L2.
- L2: the level-2 lookup. A hit goes to DONE. A miss with walks off goes to DONE with a fault. A miss with walks allowed goes to WALK.
- WALK: the table walk. An error goes to DONE with a fault; success goes to FILL.
- FILL: the refill cycle, which always goes to DONE.
- DONE: the result cycle, which always returns to IDLE.

Top module: `xlat_miss_seq`

## Requirements
- R1: `req_ready` is high only in IDLE. A request accepted there drops `req_ready` from the next cycle until the result has been delivered.
- R2: The first lookup goes to the instruction TLB when `req_instr` is 1 and to the data TLB otherwise. A level-1 hit returns that TLB's address with no fault and issues no level-2 lookup.
- R3: During every lookup, `lk_va`, `lk_asid`, `lk_vmid` and `lk_secure` equal the fields of the accepted request.
- R4: The level-2 lookup is issued only after a level-1 miss. A level-2 hit returns its address with no fault and issues no walk.
- R5: Base 1 is used when `cfg_split` is nonzero and the top `SPLIT_W` bits of the address, read unsigned, are at least `cfg_split`. Otherwise base 0 is used. `walk_base1` reports the choice.
- R6: For the chosen base, the off bit is `cfg_sd_off0`/`cfg_sd_off1` in the short format and `cfg_ld_off0`/`cfg_ld_off1` in the long format. When that bit is 1, a level-2 miss returns a fault and no walk is issued.
- R7: `walk_long` is 1 when `cfg_long_fmt` is 1, and is always 1 for hypervisor-mode and second-stage requests.
- R8: The 2-bit inner-cacheability code comes from `cfg_base0_inner`/`cfg_base1_inner` in the short format and from `cfg_ctl_inner0`/`cfg_ctl_inner1` in the long format. Codes 01 and 11 are write-back and set `walk_via_dcache`. Codes 00 (non-cacheable) and 10 (write-through) clear it.
- R9: A walk response without error produces one cycle in which `fill_l2` and the missed level-1 fill strobe are high together, with `fill_pa` equal to the walk address. In the next cycle the result is returned without a fault.
- R10: A walk response with `walk_rsp_err` returns a fault and raises no fill strobe.
- R11: `rsp_valid` is a single-cycle pulse, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Idle, request accepted |
| req_va | input | VA_W | Virtual address |
| req_asid | input | ASID_W | Address-space identifier |
| req_vmid | input | VMID_W | Virtual-machine identifier |
| req_secure | input | 1 | Security state |
| req_instr | input | 1 | 1 instruction fetch, 0 data access |
| req_hyp | input | 1 | Hypervisor-mode translation |
| req_stage2 | input | 1 | Second-stage translation |
| cfg_long_fmt | input | 1 | Long-descriptor format select |
| cfg_split | input | SPLIT_W | Base-1 region boundary, 0 disables base 1 |
| cfg_sd_off0 | input | 1 | Short format: base 0 walks off |
| cfg_sd_off1 | input | 1 | Short format: base 1 walks off |
| cfg_ld_off0 | input | 1 | Long format: base 0 walks off |
| cfg_ld_off1 | input | 1 | Long format: base 1 walks off |
| cfg_base0_inner | input | 2 | Short-format inner code, base 0 |
| cfg_base1_inner | input | 2 | Short-format inner code, base 1 |
| cfg_ctl_inner0 | input | 2 | Long-format inner code, base 0 |
| cfg_ctl_inner1 | input | 2 | Long-format inner code, base 1 |
| lk_va | output | VA_W | Lookup key: address |
| lk_asid | output | ASID_W | Lookup key: address space |
| lk_vmid | output | VMID_W | Lookup key: virtual machine |
| lk_secure | output | 1 | Lookup key: security |
| l1i_req | output | 1 | Instruction TLB lookup |
| l1i_rsp_valid | input | 1 | Instruction TLB response |
| l1i_rsp_hit | input | 1 | Instruction TLB hit |
| l1i_rsp_pa | input | PA_W | Instruction TLB address |
| l1d_req | output | 1 | Data TLB lookup |
| l1d_rsp_valid | input | 1 | Data TLB response |
| l1d_rsp_hit | input | 1 | Data TLB hit |
| l1d_rsp_pa | input | PA_W | Data TLB address |
| l2_req | output | 1 | Level-2 TLB lookup |
| l2_rsp_valid | input | 1 | Level-2 response |
| l2_rsp_hit | input | 1 | Level-2 hit |
| l2_rsp_pa | input | PA_W | Level-2 address |
| walk_req | output | 1 | Table walk request |
| walk_long | output | 1 | Walk uses long format |
| walk_base1 | output | 1 | Walk uses base 1 |
| walk_via_dcache | output | 1 | Walk reads through data cache |
| walk_rsp_valid | input | 1 | Walk response |
| walk_rsp_err | input | 1 | Walk failed |
| walk_rsp_pa | input | PA_W | Walk address |
| fill_l1i | output | 1 | Instruction TLB refill |
| fill_l1d | output | 1 | Data TLB refill |
| fill_l2 | output | 1 | Level-2 refill |
| fill_pa | output | PA_W | Refill address |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Translation fault |
| rsp_pa | output | PA_W | Translated address |

## Verification
The bench builds the block with a 16-bit address, a 12-bit physical address, 4-bit and 3-bit identifiers, and a 2-bit split field. This makes every region boundary reachable with only four address-top values. The main sweep covers the full cross of access kind, normal/hypervisor/second-stage mode, format bit, all sixteen off-bit patterns, four rotations of the inner-cacheability codes, both bases, and the four endings (level-1 hit, level-2 hit, good walk, failed walk). A second sweep pairs every split value with every address top.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_L1   = 3'd1,
        ST_L2   = 3'd2,
        ST_WALK = 3'd3,
        ST_FILL = 3'd4,
        ST_DONE = 3'd5
    } seq_state_e;

    localparam int INNER_W = 2;

    // Write-back codes (01, 11) share bit 0 set; 00 and 10 do not.
    function automatic logic inner_is_wb(input logic [INNER_W-1:0] code);
        return code[0];
    endfunction

endpackage

// File: rtl/xlat_req_hold.sv
module xlat_req_hold #(
    parameter int VA_W   = 32,
    parameter int ASID_W = 8,
    parameter int VMID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [VA_W-1:0]   in_va,
    input  logic [ASID_W-1:0] in_asid,
    input  logic [VMID_W-1:0] in_vmid,
    input  logic              in_secure,
    input  logic              in_instr,
    input  logic              in_hyp,
    input  logic              in_stage2,
    output logic [VA_W-1:0]   hold_va,
    output logic [ASID_W-1:0] hold_asid,
    output logic [VMID_W-1:0] hold_vmid,
    output logic              hold_secure,
    output logic              hold_instr,
    output logic              hold_hyp,
    output logic              hold_stage2
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_va     <= '0;
            hold_asid   <= '0;
            hold_vmid   <= '0;
            hold_secure <= 1'b0;
            hold_instr  <= 1'b0;
            hold_hyp    <= 1'b0;
            hold_stage2 <= 1'b0;
        end else if (capture) begin
            hold_va     <= in_va;
            hold_asid   <= in_asid;
            hold_vmid   <= in_vmid;
            hold_secure <= in_secure;
            hold_instr  <= in_instr;
            hold_hyp    <= in_hyp;
            hold_stage2 <= in_stage2;
        end
    end

endmodule

// File: rtl/xlat_walk_policy.sv
module xlat_walk_policy
    import xlat_pkg::*;
#(
    parameter int SPLIT_W = 3
) (
    input  logic [SPLIT_W-1:0] va_top,
    input  logic               hyp,
    input  logic               stage2,
    input  logic               long_fmt_bit,
    input  logic [SPLIT_W-1:0] split,
    input  logic               sd_off0,
    input  logic               sd_off1,
    input  logic               ld_off0,
    input  logic               ld_off1,
    input  logic [INNER_W-1:0] base0_inner,
    input  logic [INNER_W-1:0] base1_inner,
    input  logic [INNER_W-1:0] ctl_inner0,
    input  logic [INNER_W-1:0] ctl_inner1,
    output logic               use_base1,
    output logic               use_long,
    output logic               walk_off,
    output logic               via_dcache
);

    logic [INNER_W-1:0] inner_sel;

    always_comb begin
        use_base1 = (split != '0) && (va_top >= split);
        use_long  = long_fmt_bit | hyp | stage2;
        if (use_long) begin
            walk_off  = use_base1 ? ld_off1 : ld_off0;
            inner_sel = use_base1 ? ctl_inner1 : ctl_inner0;
        end else begin
            walk_off  = use_base1 ? sd_off1 : sd_off0;
            inner_sel = use_base1 ? base1_inner : base0_inner;
        end
        via_dcache = inner_is_wb(inner_sel);
    end

endmodule

// File: rtl/xlat_seq_fsm.sv
module xlat_seq_fsm
    import xlat_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    output logic            capture,
    input  logic            is_instr,
    input  logic            walk_off,
    output logic            l1i_req,
    input  logic            l1i_rsp_valid,
    input  logic            l1i_rsp_hit,
    input  logic [PA_W-1:0] l1i_rsp_pa,
    output logic            l1d_req,
    input  logic            l1d_rsp_valid,
    input  logic            l1d_rsp_hit,
    input  logic [PA_W-1:0] l1d_rsp_pa,
    output logic            l2_req,
    input  logic            l2_rsp_valid,
    input  logic            l2_rsp_hit,
    input  logic [PA_W-1:0] l2_rsp_pa,
    output logic            walk_req,
    input  logic            walk_rsp_valid,
    input  logic            walk_rsp_err,
    input  logic [PA_W-1:0] walk_rsp_pa,
    output logic            fill_l1i,
    output logic            fill_l1d,
    output logic            fill_l2,
    output logic [PA_W-1:0] fill_pa,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic [PA_W-1:0] rsp_pa
);

    seq_state_e      state, state_nxt;
    logic [PA_W-1:0] res_pa;
    logic            res_fault;
    logic            l1_valid, l1_hit;
    logic [PA_W-1:0] l1_pa;

    // Response of the level-1 TLB that matches the access kind
    always_comb begin
        l1_valid = is_instr ? l1i_rsp_valid : l1d_rsp_valid;
        l1_hit   = is_instr ? l1i_rsp_hit   : l1d_rsp_hit;
        l1_pa    = is_instr ? l1i_rsp_pa    : l1d_rsp_pa;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid)      state_nxt = ST_L1;
            ST_L1:   if (l1_valid)       state_nxt = l1_hit ? ST_DONE : ST_L2;
            ST_L2:   if (l2_rsp_valid)   state_nxt = (l2_rsp_hit || walk_off) ? ST_DONE : ST_WALK;
            ST_WALK: if (walk_rsp_valid) state_nxt = walk_rsp_err ? ST_DONE : ST_FILL;
            ST_FILL:                     state_nxt = ST_DONE;
            ST_DONE:                     state_nxt = ST_IDLE;
            default:                     state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Result register: written by whichever stage ends the request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_pa    <= '0;
            res_fault <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    res_pa    <= '0;
                    res_fault <= 1'b0;
                end
                ST_L1: if (l1_valid && l1_hit) begin
                    res_pa    <= l1_pa;
                    res_fault <= 1'b0;
                end
                ST_L2: if (l2_rsp_valid) begin
                    if (l2_rsp_hit) begin
                        res_pa    <= l2_rsp_pa;
                        res_fault <= 1'b0;
                    end else if (walk_off) begin
                        res_pa    <= '0;
                        res_fault <= 1'b1;
                    end
                end
                ST_WALK: if (walk_rsp_valid) begin
                    res_pa    <= walk_rsp_err ? '0 : walk_rsp_pa;
                    res_fault <= walk_rsp_err;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        capture   = req_ready && req_valid;
        l1i_req   = (state == ST_L1) &&  is_instr;
        l1d_req   = (state == ST_L1) && !is_instr;
        l2_req    = (state == ST_L2);
        walk_req  = (state == ST_WALK);
        fill_l2   = (state == ST_FILL);
        fill_l1i  = (state == ST_FILL) &&  is_instr;
        fill_l1d  = (state == ST_FILL) && !is_instr;
        fill_pa   = res_pa;
        rsp_valid = (state == ST_DONE);
        rsp_fault = res_fault;
        rsp_pa    = res_pa;
    end

    a_r1_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_one_lookup_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({l1i_req, l1d_req, l2_req, walk_req}));

    a_r4_l2_after_l1_miss: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l2_req) |-> $past(l1_valid && !l1_hit));

    a_r6_no_walk_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !walk_off);

    a_r9_fill_after_good_walk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_l2) |-> $past(walk_rsp_valid && !walk_rsp_err));

    a_r10_error_is_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && walk_rsp_valid && walk_rsp_err) |=> (rsp_valid && rsp_fault && !fill_l2));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/xlat_miss_seq.sv
module xlat_miss_seq
    import xlat_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 40,
    parameter int ASID_W  = 8,
    parameter int VMID_W  = 8,
    parameter int SPLIT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_va,
    input  logic [ASID_W-1:0]  req_asid,
    input  logic [VMID_W-1:0]  req_vmid,
    input  logic               req_secure,
    input  logic               req_instr,
    input  logic               req_hyp,
    input  logic               req_stage2,
    input  logic               cfg_long_fmt,
    input  logic [SPLIT_W-1:0] cfg_split,
    input  logic               cfg_sd_off0,
    input  logic               cfg_sd_off1,
    input  logic               cfg_ld_off0,
    input  logic               cfg_ld_off1,
    input  logic [1:0]         cfg_base0_inner,
    input  logic [1:0]         cfg_base1_inner,
    input  logic [1:0]         cfg_ctl_inner0,
    input  logic [1:0]         cfg_ctl_inner1,
    output logic [VA_W-1:0]    lk_va,
    output logic [ASID_W-1:0]  lk_asid,
    output logic [VMID_W-1:0]  lk_vmid,
    output logic               lk_secure,
    output logic               l1i_req,
    input  logic               l1i_rsp_valid,
    input  logic               l1i_rsp_hit,
    input  logic [PA_W-1:0]    l1i_rsp_pa,
    output logic               l1d_req,
    input  logic               l1d_rsp_valid,
    input  logic               l1d_rsp_hit,
    input  logic [PA_W-1:0]    l1d_rsp_pa,
    output logic               l2_req,
    input  logic               l2_rsp_valid,
    input  logic               l2_rsp_hit,
    input  logic [PA_W-1:0]    l2_rsp_pa,
    output logic               walk_req,
    output logic               walk_long,
    output logic               walk_base1,
    output logic               walk_via_dcache,
    input  logic               walk_rsp_valid,
    input  logic               walk_rsp_err,
    input  logic [PA_W-1:0]    walk_rsp_pa,
    output logic               fill_l1i,
    output logic               fill_l1d,
    output logic               fill_l2,
    output logic [PA_W-1:0]    fill_pa,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [PA_W-1:0]    rsp_pa
);

    localparam int TOP_LSB = VA_W - SPLIT_W;

    logic capture;
    logic hold_instr, hold_hyp, hold_stage2;
    logic walk_off;

    xlat_req_hold #(.VA_W(VA_W), .ASID_W(ASID_W), .VMID_W(VMID_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .in_va       (req_va),
        .in_asid     (req_asid),
        .in_vmid     (req_vmid),
        .in_secure   (req_secure),
        .in_instr    (req_instr),
        .in_hyp      (req_hyp),
        .in_stage2   (req_stage2),
        .hold_va     (lk_va),
        .hold_asid   (lk_asid),
        .hold_vmid   (lk_vmid),
        .hold_secure (lk_secure),
        .hold_instr  (hold_instr),
        .hold_hyp    (hold_hyp),
        .hold_stage2 (hold_stage2)
    );

    xlat_walk_policy #(.SPLIT_W(SPLIT_W)) u_policy (
        .va_top       (lk_va[VA_W-1:TOP_LSB]),
        .hyp          (hold_hyp),
        .stage2       (hold_stage2),
        .long_fmt_bit (cfg_long_fmt),
        .split        (cfg_split),
        .sd_off0      (cfg_sd_off0),
        .sd_off1      (cfg_sd_off1),
        .ld_off0      (cfg_ld_off0),
        .ld_off1      (cfg_ld_off1),
        .base0_inner  (cfg_base0_inner),
        .base1_inner  (cfg_base1_inner),
        .ctl_inner0   (cfg_ctl_inner0),
        .ctl_inner1   (cfg_ctl_inner1),
        .use_base1    (walk_base1),
        .use_long     (walk_long),
        .walk_off     (walk_off),
        .via_dcache   (walk_via_dcache)
    );

    xlat_seq_fsm #(.PA_W(PA_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .capture        (capture),
        .is_instr       (hold_instr),
        .walk_off       (walk_off),
        .l1i_req        (l1i_req),
        .l1i_rsp_valid  (l1i_rsp_valid),
        .l1i_rsp_hit    (l1i_rsp_hit),
        .l1i_rsp_pa     (l1i_rsp_pa),
        .l1d_req        (l1d_req),
        .l1d_rsp_valid  (l1d_rsp_valid),
        .l1d_rsp_hit    (l1d_rsp_hit),
        .l1d_rsp_pa     (l1d_rsp_pa),
        .l2_req         (l2_req),
        .l2_rsp_valid   (l2_rsp_valid),
        .l2_rsp_hit     (l2_rsp_hit),
        .l2_rsp_pa      (l2_rsp_pa),
        .walk_req       (walk_req),
        .walk_rsp_valid (walk_rsp_valid),
        .walk_rsp_err   (walk_rsp_err),
        .walk_rsp_pa    (walk_rsp_pa),
        .fill_l1i       (fill_l1i),
        .fill_l1d       (fill_l1d),
        .fill_l2        (fill_l2),
        .fill_pa        (fill_pa),
        .rsp_valid      (rsp_valid),
        .rsp_fault      (rsp_fault),
        .rsp_pa         (rsp_pa)
    );

    a_r7_forced_long: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && (hold_hyp || hold_stage2)) |-> walk_long);

    a_r3_key_stable_in_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_req && $past(l1i_req || l1d_req)) |-> $stable(lk_va) && $stable(lk_asid));

endmodule

// File: tb/test_xlat_miss_seq.sv
`timescale 1ns/1ps
module test_xlat_miss_seq;

    localparam int VA_W = 16, PA_W = 12, ASID_W = 4, VMID_W = 3, SPLIT_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              req_valid = 0, req_ready;
    logic [VA_W-1:0]   req_va = '0;
    logic [ASID_W-1:0] req_asid = '0;
    logic [VMID_W-1:0] req_vmid = '0;
    logic              req_secure = 0, req_instr = 0, req_hyp = 0, req_stage2 = 0;
    logic              cfg_long_fmt = 0;
    logic [SPLIT_W-1:0] cfg_split = '0;
    logic              cfg_sd_off0 = 0, cfg_sd_off1 = 0, cfg_ld_off0 = 0, cfg_ld_off1 = 0;
    logic [1:0]        cfg_base0_inner = 0, cfg_base1_inner = 0, cfg_ctl_inner0 = 0, cfg_ctl_inner1 = 0;
    logic [VA_W-1:0]   lk_va;
    logic [ASID_W-1:0] lk_asid;
    logic [VMID_W-1:0] lk_vmid;
    logic              lk_secure;
    logic              l1i_req, l1i_rsp_valid = 0, l1i_rsp_hit = 0;
    logic [PA_W-1:0]   l1i_rsp_pa = '0;
    logic              l1d_req, l1d_rsp_valid = 0, l1d_rsp_hit = 0;
    logic [PA_W-1:0]   l1d_rsp_pa = '0;
    logic              l2_req, l2_rsp_valid = 0, l2_rsp_hit = 0;
    logic [PA_W-1:0]   l2_rsp_pa = '0;
    logic              walk_req, walk_long, walk_base1, walk_via_dcache;
    logic              walk_rsp_valid = 0, walk_rsp_err = 0;
    logic [PA_W-1:0]   walk_rsp_pa = '0;
    logic              fill_l1i, fill_l1d, fill_l2;
    logic [PA_W-1:0]   fill_pa;
    logic              rsp_valid, rsp_fault;
    logic [PA_W-1:0]   rsp_pa;

    xlat_miss_seq #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .VMID_W(VMID_W), .SPLIT_W(SPLIT_W))
    i_xlat_miss_seq (.*);

    int nchk = 0, nerr = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // path: 0 level-1 hit, 1 level-2 hit, 2 good walk, 3 failed walk
    task automatic run_txn(input logic instr, input logic hyp, input logic s2,
                           input logic [VA_W-1:0] va, input int path);
        logic [ASID_W-1:0] asid = va[3:0] ^ 4'h5;
        logic [VMID_W-1:0] vmid = va[6:4];
        logic sec = va[7];
        logic [PA_W-1:0] pa1 = 12'h100 ^ va[11:0];
        logic [PA_W-1:0] pa2 = 12'h200 ^ va[11:0];
        logic [PA_W-1:0] paw = 12'h300 ^ va[11:0];
        logic e_long, e_b1, e_off, e_dc, e_walk, e_fill, e_fault;
        logic [1:0] inner;
        logic [PA_W-1:0] e_pa;
        logic s_l1i = 0, s_l1d = 0, s_l2 = 0, s_walk = 0, s_fl2 = 0, s_fl1i = 0, s_fl1d = 0, s_rsp = 0;
        logic g_long = 0, g_b1 = 0, g_dc = 0, g_fault = 0;
        logic [PA_W-1:0] g_pa = '0, g_fpa = '0;
        int keybad = 0;

        e_long = cfg_long_fmt | hyp | s2;
        e_b1   = (cfg_split != 0) && (va[VA_W-1 -: SPLIT_W] >= cfg_split);
        e_off  = e_long ? (e_b1 ? cfg_ld_off1 : cfg_ld_off0) : (e_b1 ? cfg_sd_off1 : cfg_sd_off0);
        inner  = e_long ? (e_b1 ? cfg_ctl_inner1 : cfg_ctl_inner0) : (e_b1 ? cfg_base1_inner : cfg_base0_inner);
        e_dc   = (inner == 2'b01) || (inner == 2'b11);
        e_walk = (path >= 2) && !e_off;
        e_fill = (path == 2) && !e_off;
        e_fault = (path >= 2) && (e_off || path == 3);
        e_pa   = (path == 0) ? pa1 : (path == 1) ? pa2 : e_fault ? '0 : paw;

        @(negedge clk);
        chk("R1 ready in idle", req_ready, 1);
        req_valid = 1; req_va = va; req_asid = asid; req_vmid = vmid; req_secure = sec;
        req_instr = instr; req_hyp = hyp; req_stage2 = s2;
        @(negedge clk);
        req_valid = 0;
        chk("R1 busy after accept", req_ready, 0);
        for (int c = 0; c < 20; c++) begin
            l1i_rsp_valid = 0; l1d_rsp_valid = 0; l2_rsp_valid = 0; walk_rsp_valid = 0;
            if (rsp_valid) begin
                s_rsp = 1; g_fault = rsp_fault; g_pa = rsp_pa;
                break;
            end
            if (l1i_req || l1d_req || l2_req) begin
                if (lk_va !== va || lk_asid !== asid || lk_vmid !== vmid || lk_secure !== sec) keybad++;
            end
            if (l1i_req) begin s_l1i = 1; l1i_rsp_valid = 1; l1i_rsp_hit = (path == 0); l1i_rsp_pa = pa1; end
            if (l1d_req) begin s_l1d = 1; l1d_rsp_valid = 1; l1d_rsp_hit = (path == 0); l1d_rsp_pa = pa1; end
            if (l2_req)  begin s_l2 = 1; l2_rsp_valid = 1; l2_rsp_hit = (path == 1); l2_rsp_pa = pa2; end
            if (walk_req) begin
                s_walk = 1; g_long = walk_long; g_b1 = walk_base1; g_dc = walk_via_dcache;
                walk_rsp_valid = 1; walk_rsp_err = (path == 3); walk_rsp_pa = paw;
            end
            if (fill_l2)  begin s_fl2 = 1; g_fpa = fill_pa; end
            if (fill_l1i) s_fl1i = 1;
            if (fill_l1d) s_fl1d = 1;
            @(negedge clk);
        end
        l1i_rsp_valid = 0; l1d_rsp_valid = 0; l2_rsp_valid = 0; walk_rsp_valid = 0;

        chk("R2 instruction TLB asked", s_l1i, instr);
        chk("R2 data TLB asked", s_l1d, !instr);
        chk("R3 lookup key", keybad, 0);
        chk("R4 level-2 only after miss", s_l2, path >= 1);
        chk("R6 walk issued", s_walk, e_walk);
        if (e_walk) begin
            chk("R7 format", g_long, e_long);
            chk("R5 base select", g_b1, e_b1);
            chk("R8 cache route", g_dc, e_dc);
        end
        chk("R9 R10 level-2 fill", s_fl2, e_fill);
        chk("R9 level-1 fill", {s_fl1i, s_fl1d}, e_fill ? {instr, !instr} : 2'b00);
        if (e_fill) chk("R9 fill address", g_fpa, paw);
        chk("R11 result delivered", s_rsp, 1);
        chk("R6 R10 fault", g_fault, e_fault);
        chk("R2 R4 R9 result address", g_pa, e_pa);
        @(negedge clk);
        chk("R11 single pulse", rsp_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int seq = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset ready", req_ready, 1);
        chk("R11 reset no result", rsp_valid, 0);
        chk("R2 reset no lookup", {l1i_req, l1d_req, l2_req, walk_req}, 0);
        rst_n = 1;
        @(negedge clk);

        // Main sweep: base 1 region starts at top value 2
        cfg_split = 2'd2;
        for (int instr = 0; instr < 2; instr++)
        for (int mode = 0; mode < 3; mode++)
        for (int eae = 0; eae < 2; eae++)
        for (int offs = 0; offs < 16; offs++)
        for (int k = 0; k < 4; k++)
        for (int b1 = 0; b1 < 2; b1++)
        for (int path = 0; path < 4; path++) begin
            cfg_long_fmt = eae[0];
            {cfg_ld_off1, cfg_ld_off0, cfg_sd_off1, cfg_sd_off0} = offs[3:0];
            cfg_base0_inner = 2'(k);     cfg_base1_inner = 2'(k + 1);
            cfg_ctl_inner0  = 2'(k + 2); cfg_ctl_inner1  = 2'(k + 3);
            seq++;
            run_txn(instr[0], mode == 1, mode == 2,
                    {(b1 != 0) ? 2'd3 : 2'd1, 14'(seq * 37)}, path);
        end

        // Boundary sweep of split value against address top (R5)
        cfg_long_fmt = 0;
        {cfg_ld_off1, cfg_ld_off0, cfg_sd_off1, cfg_sd_off0} = 4'b0000;
        for (int sp = 0; sp < 4; sp++)
        for (int top = 0; top < 4; top++) begin
            cfg_split = 2'(sp);
            run_txn(1'b0, 1'b0, 1'b0, {2'(top), 14'h0a5}, 2);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule